// File: doc/BRIEF.md
# Compare-Triggered Conversion Start Unit

This unit pairs two free-running 16-bit timers with a 16-bit compare register. When the mode field holds the special-event code, a match between the chosen timer and the compare value makes a one-cycle trigger. That trigger sends the timer back to zero, so the next match comes after the same interval. The trigger also asks an external analog-to-digital converter for a new sample, but only while the converter is switched on and idle. The result is a conversion rate set by hardware, and software does little more than collect each result.

Software reaches the unit through a small register port. Writes take effect at the next clock edge, and reads are combinational. The converter side is a start pulse plus a channel number going out, and a completion pulse plus a 10-bit sample coming back. When a conversion completes, the go bit clears, the sample is stored and a sticky interrupt flag is raised. Software can also start a conversion directly by writing the go bit.

Top module: `trig_conv_unit`

Register addresses (3-bit): 0 compare value; 1 mode (bits 3:0 mode code, bit 4 timer select); 2 converter control; 3 result (bits 9:0); 4 status (bit 0 interrupt flag); 5 timer A count; 6 timer B count; 7 reads zero.

## Requirements
- R1: The timer reset and conversion trigger happen only while mode bits 3:0 equal 4'b1011. With any other code, both timers count up by one every cycle straight through the compare value, and no conversion starts.
- R2: In a cycle where the mode is 4'b1011, the selected timer equals the compare value, the enable bit is 1 and no conversion is running, the go bit reads 1 from the next cycle. In that next cycle `conv_start_o` is high for exactly one cycle and `conv_chan_o` carries the channel field.
- R3: Every trigger clears the selected timer, so that timer reads 0 in the cycle after the one where it equalled the compare value.
- R4: With the enable bit at 0, a trigger starts no conversion, but it still clears the selected timer.
- R5: Mode bit 4 picks the time base: 0 selects timer A (address 5) and 1 selects timer B (address 6). Only the selected timer is compared and cleared. The other one keeps counting by one every cycle.
- R6: The converter control register (address 2) holds the channel in bits 5:2, the go bit in bit 1 and the enable bit in bit 0. Bits 15:6 always read 0.
- R7: After reset, the compare, mode, control, result and status registers all read 0.
- R8: The go bit stays 1 until the converter reports completion. At that clock edge, go returns to 0 and the converter's sample is latched into the result register.
- R9: Completion sets the status bit 0 interrupt flag, which also drives `irq_o`. Writing 0 to status bit 0 leaves the flag set. Writing 1 to status bit 0 clears it.
- R10: A trigger that arrives while the go bit is 1 starts nothing new, but the timer is still cleared.
- R11: Writing 1 to the go bit starts a conversion only if the enable bit in the same write is 1. Otherwise the go bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| conv_chan_o | output | 4 | Channel to convert |
| conv_done_i | input | 1 | One-cycle completion pulse from the converter |
| conv_result_i | input | 10 | Converted sample, valid with conv_done_i |
| irq_o | output | 1 | Sticky conversion-complete flag |

## Verification
The trigger path is exercised with four settings:
- Special-event mode with the enable bit set.
- Special-event mode with the enable bit clear.
- A mode code that differs by one bit from the special-event code.
- A compare period shorter than the conversion latency.

Together these separate timer clearing from conversion launch, and show that a trigger arriving during a conversion is dropped. Each time base is selected in turn, and the unselected timer is watched while the other one wraps. This exposes a design that clears the wrong counter. Software go writes, made with the enable bit set and with it clear, are checked against the start pulses the scoreboard expects. Completion results are compared with the values the converter stub returned.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
    localparam int TMR_W   = 16;
    localparam int RES_W   = 10;
    localparam int CHAN_W  = 4;
    localparam int MODE_W  = 4;
    localparam int ADDR_W  = 3;
    localparam int NUM_TMR = 2;
    localparam logic [MODE_W-1:0] MODE_SPECIAL = 4'b1011;

    typedef enum logic [ADDR_W-1:0] {
        A_CMP  = 3'd0,
        A_MODE = 3'd1,
        A_CTRL = 3'd2,
        A_RES  = 3'd3,
        A_STAT = 3'd4,
        A_TMRA = 3'd5,
        A_TMRB = 3'd6
    } addr_e;
endpackage

// File: rtl/tcs_timers.sv
module tcs_timers #(
    parameter  int W  = 16,
    parameter  int N  = 2,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic [SW-1:0]       sel_i,
    output logic [N-1:0][W-1:0] cnt_o
);
    typedef struct packed {
        logic [N-1:0][W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        for (int i = 0; i < N; i++) begin
            if (clr_i && (sel_i == SW'(i))) begin
                tmr_d.cnt[i] = '0;
            end else begin
                tmr_d.cnt[i] = tmr_q.cnt[i] + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign cnt_o = tmr_q.cnt;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_SEL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && sel_i == SW'(g)) |=> (tmr_q.cnt[g] == '0)); // R3
        AST_OTHER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
            !(clr_i && sel_i == SW'(g)) |=> (tmr_q.cnt[g] == $past(tmr_q.cnt[g]) + W'(1))); // R5
    end
endmodule

// File: rtl/tcs_regs.sv
module tcs_regs
    import tcs_pkg::*;
#(
    parameter  int TW = TMR_W,
    parameter  int RW = RES_W,
    parameter  int CW = CHAN_W,
    parameter  int MW = MODE_W,
    parameter  int AW = ADDR_W,
    localparam int KW = CW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [TW-1:0]       wr_data,
    input  logic [AW-1:0]       rd_addr,
    input  logic [KW-1:0]       ctrl_word_i,
    input  logic [RW-1:0]       result_i,
    input  logic                irq_i,
    input  logic [1:0][TW-1:0]  tmr_i,
    output logic [TW-1:0]       rd_data,
    output logic [TW-1:0]       cmp_o,
    output logic [MW-1:0]       mode_o,
    output logic                sel_o,
    output logic                wr_ctrl_o,
    output logic                wr_stat_o
);
    typedef struct packed {
        logic [TW-1:0] cmp;
        logic [MW-1:0] mode;
        logic          sel;
    } regs_s;

    regs_s reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en && wr_addr == A_CMP) begin
            reg_d.cmp = wr_data;
        end
        if (wr_en && wr_addr == A_MODE) begin
            reg_d.mode = wr_data[MW-1:0];
            reg_d.sel  = wr_data[MW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMP:   rd_data = reg_q.cmp;
            A_MODE:  rd_data = TW'({reg_q.sel, reg_q.mode});
            A_CTRL:  rd_data = TW'(ctrl_word_i);
            A_RES:   rd_data = TW'(result_i);
            A_STAT:  rd_data = TW'(irq_i);
            A_TMRA:  rd_data = tmr_i[0];
            A_TMRB:  rd_data = tmr_i[1];
            default: rd_data = '0;
        endcase
    end

    assign cmp_o     = reg_q.cmp;
    assign mode_o    = reg_q.mode;
    assign sel_o     = reg_q.sel;
    assign wr_ctrl_o = wr_en && (wr_addr == A_CTRL);
    assign wr_stat_o = wr_en && (wr_addr == A_STAT);

    AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_MODE) |=> $stable(reg_q.mode)); // R1
endmodule

// File: rtl/tcs_conv_ctrl.sv
module tcs_conv_ctrl
    import tcs_pkg::*;
#(
    parameter  int RW = RES_W,
    parameter  int CW = CHAN_W,
    localparam int KW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic          wr_ctrl_i,
    input  logic          wr_stat_i,
    input  logic [KW-1:0] wdata_i,
    input  logic          done_i,
    input  logic [RW-1:0] result_i,
    output logic          start_o,
    output logic [CW-1:0] chan_o,
    output logic [KW-1:0] ctrl_word_o,
    output logic [RW-1:0] result_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [CW-1:0] chan;
        logic          go;
        logic          en;
        logic          start;
        logic [RW-1:0] result;
        logic          irq;
    } conv_s;

    conv_s cv_d, cv_q;
    logic  sw_go;
    logic  finish;

    always_comb begin
        cv_d       = cv_q;
        cv_d.start = 1'b0;
        sw_go      = wr_ctrl_i && wdata_i[1];
        finish     = cv_q.go && done_i;

        if (wr_ctrl_i) begin
            cv_d.chan = wdata_i[KW-1:2];
            cv_d.en   = wdata_i[0];
        end

        if (wr_stat_i && wdata_i[0]) begin
            cv_d.irq = 1'b0;
        end

        if (finish) begin
            cv_d.go     = 1'b0;
            cv_d.result = result_i;
            cv_d.irq    = 1'b1;
        end else if (!cv_q.go && cv_d.en && (trig_i || sw_go)) begin
            cv_d.go    = 1'b1;
            cv_d.start = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cv_q <= '0;
        else        cv_q <= cv_d;
    end

    assign start_o     = cv_q.start;
    assign chan_o      = cv_q.chan;
    assign ctrl_word_o = {cv_q.chan, cv_q.go, cv_q.en};
    assign result_o    = cv_q.result;
    assign irq_o       = cv_q.irq;

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        cv_q.start |-> (cv_q.en && cv_q.go)); // R2
    AST_GO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_q.go && !done_i) |=> cv_q.go); // R8
    AST_DONE_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_q.go && done_i) |=> (!cv_q.go && cv_q.irq && cv_q.result == $past(result_i))); // R8
    AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cv_q.go |=> !cv_q.start); // R10
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_q.irq && !(wr_stat_i && wdata_i[0])) |=> cv_q.irq); // R9
endmodule

// File: rtl/trig_conv_unit.sv
module trig_conv_unit
    import tcs_pkg::*;
#(
    parameter  int TW = TMR_W,
    parameter  int RW = RES_W,
    parameter  int CW = CHAN_W,
    parameter  int MW = MODE_W,
    parameter  int AW = ADDR_W,
    localparam int KW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [TW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [TW-1:0] rd_data,
    output logic          conv_start_o,
    output logic [CW-1:0] conv_chan_o,
    input  logic          conv_done_i,
    input  logic [RW-1:0] conv_result_i,
    output logic          irq_o
);
    logic [NUM_TMR-1:0][TW-1:0] tmr;
    logic [TW-1:0]              cmp;
    logic [MW-1:0]              mode;
    logic                       sel;
    logic                       wr_ctrl;
    logic                       wr_stat;
    logic [KW-1:0]              ctrl_word;
    logic [RW-1:0]              result;
    logic                       trig;

    assign trig = (mode == MODE_SPECIAL) && (tmr[sel] == cmp);

    tcs_timers #(.W(TW), .N(NUM_TMR)) u_timers (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (trig),
        .sel_i (sel),
        .cnt_o (tmr)
    );

    tcs_regs #(.TW(TW), .RW(RW), .CW(CW), .MW(MW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .ctrl_word_i (ctrl_word),
        .result_i    (result),
        .irq_i       (irq_o),
        .tmr_i       (tmr),
        .rd_data     (rd_data),
        .cmp_o       (cmp),
        .mode_o      (mode),
        .sel_o       (sel),
        .wr_ctrl_o   (wr_ctrl),
        .wr_stat_o   (wr_stat)
    );

    tcs_conv_ctrl #(.RW(RW), .CW(CW)) u_conv (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig),
        .wr_ctrl_i   (wr_ctrl),
        .wr_stat_i   (wr_stat),
        .wdata_i     (wr_data[KW-1:0]),
        .done_i      (conv_done_i),
        .result_i    (conv_result_i),
        .start_o     (conv_start_o),
        .chan_o      (conv_chan_o),
        .ctrl_word_o (ctrl_word),
        .result_o    (result),
        .irq_o       (irq_o)
    );

    AST_TRIG_NOT_IN_OTHER_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SPECIAL) |=> !conv_start_o || $past(wr_ctrl)); // R1
endmodule

// File: tb/test_trig_conv_unit.sv
module test_trig_conv_unit;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        conv_start_o;
    logic [3:0]  conv_chan_o;
    logic        conv_done_i;
    logic [9:0]  conv_result_i;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int k_conv = 0;

    always #10 clk = ~clk;

    trig_conv_unit i_trig_conv_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .conv_start_o  (conv_start_o),
        .conv_chan_o   (conv_chan_o),
        .conv_done_i   (conv_done_i),
        .conv_result_i (conv_result_i),
        .irq_o         (irq_o)
    );

    // Behavioural converter stub
    logic [3:0] st_cnt;
    logic [3:0] st_ch;
    int         st_n;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_cnt <= '0; st_ch <= '0; st_n <= 0;
            conv_done_i <= 1'b0; conv_result_i <= '0;
        end else begin
            conv_done_i <= 1'b0;
            if (conv_start_o) begin
                st_cnt <= 4'(LAT);
                st_ch  <= conv_chan_o;
            end else if (st_cnt != 0) begin
                st_cnt <= st_cnt - 4'd1;
                if (st_cnt == 4'd1) begin
                    conv_done_i   <= 1'b1;
                    conv_result_i <= {st_ch, 6'(st_n)};
                    st_n          <= st_n + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: each start pulse pops an expected channel
    always @(negedge clk) begin
        if (rst_n && conv_start_o) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2/R4/R10/R11 unexpected start actual chan %0h expected none", conv_chan_o);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (int'(conv_chan_o) != e) begin
                    errors++;
                    $display("FAIL R2 start channel actual %0h expected %0h", conv_chan_o, e);
                end
            end
        end
    end

    task automatic push_exp(input int ch);
        exp_q.push_back(ch);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_start(input string req);
        int n = 0;
        while (!conv_start_o && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(req, int'(conv_start_o), 1);
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq_o && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(req, int'(irq_o), 1);
    endtask

    // Watch a timer for n cycles; resets expected when it equals cv and resets are on
    task automatic watch(input logic [2:0] a, input int n, input int cv, input bit rst_on,
                         input string req, output int zeros);
        int prev;
        int v;
        int e;
        int bad = 0;
        zeros = 0;
        rd(a, prev);
        for (int i = 0; i < n; i++) begin
            rd(a, v);
            e = (rst_on && prev == cv) ? 0 : ((prev + 1) & 16'hFFFF);
            if (v != e && bad == 0) begin
                bad = 1;
                chk(req, v, e);
            end
            if (v == 0) zeros++;
            prev = v;
        end
        if (bad == 0) chk(req, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int a;
        int z;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: register reset values
        rd(3'd0, v); chk("R7 compare", v, 0);
        rd(3'd1, v); chk("R7 mode", v, 0);
        rd(3'd2, v); chk("R7 control", v, 0);
        rd(3'd3, v); chk("R7 result", v, 0);
        rd(3'd4, v); chk("R7 status", v, 0);

        // R6: unimplemented control bits read zero; go with en=0 does not set (R11)
        wr(3'd2, 16'hFFFC);
        rd(3'd2, v); chk("R6 control layout", v, 16'h003C);

        // R1: near-miss mode code, timer passes compare untouched
        wr(3'd1, 16'h000A);
        rd(3'd5, a);
        wr(3'd0, 16'(a + 10));
        watch(3'd5, 30, a + 10, 1'b0, "R1 no reset outside special mode", z);

        // R2, R3, R8, R9: enabled special-event conversion on timer A
        wr(3'd2, 16'h0015);
        rd(3'd5, a);
        wr(3'd0, 16'(a + 10));
        push_exp(5);
        wr(3'd1, 16'h000B);
        wait_start("R2 start pulse");
        rd(3'd2, v); chk("R2 go set while busy", v, 16'h0017);
        rd(3'd5, v); chk("R3 timer restarted", int'(v < 8), 1);
        rd(3'd2, v); chk("R8 go held while busy", v, 16'h0017);
        wait_irq("R9 irq on completion");
        wr(3'd1, 16'h0000);
        rd(3'd2, v); chk("R8 go cleared at completion", v, 16'h0015);
        rd(3'd3, v); chk("R8 result latched", v, (5 << 6) | k_conv);
        k_conv++;
        wr(3'd4, 16'h0000);
        rd(3'd4, v); chk("R9 flag kept by write of 0", v, 1);
        wr(3'd4, 16'h0001);
        rd(3'd4, v); chk("R9 flag cleared by write of 1", v, 0);

        // R4: enable clear, trigger still resets timer A
        wr(3'd2, 16'h0018);
        rd(3'd5, a);
        wr(3'd0, 16'(a + 10));
        wr(3'd1, 16'h000B);
        v = 1;
        for (int i = 0; i < 200 && v != 0; i++) rd(3'd5, v);
        chk("R4 timer reset with converter off", v, 0);
        wr(3'd0, 16'd3);
        watch(3'd5, 30, 3, 1'b1, "R4 periodic reset without conversion", z);
        chk("R4 resets seen", int'(z >= 5), 1);

        // R10: short period, triggers during conversion are dropped
        push_exp(6);
        wr(3'd2, 16'h0019);
        wait_start("R10 first start");
        wr(3'd2, 16'h0018);
        watch(3'd5, 30, 3, 1'b1, "R10 timer reset during conversion", z);
        chk("R10 completion", int'(irq_o), 1);
        rd(3'd3, v); chk("R10 single result", v, (6 << 6) | k_conv);
        k_conv++;
        wr(3'd4, 16'h0001);

        // R5: timer B selected, timer A free-running
        rd(3'd6, a);
        wr(3'd0, 16'(a + 10));
        wr(3'd1, 16'h001B);
        watch(3'd6, 30, a + 10, 1'b1, "R5 timer B reset when selected", z);
        chk("R5 timer B reset seen", int'(z >= 1), 1);
        wr(3'd0, 16'd5);
        watch(3'd5, 30, 0, 1'b0, "R5 timer A untouched", z);
        wr(3'd1, 16'h0000);

        // R11: software go
        wr(3'd2, 16'h000E);
        rd(3'd2, v); chk("R11 go ignored with enable clear", v, 16'h000C);
        push_exp(3);
        wr(3'd2, 16'h000F);
        wait_start("R11 software start");
        wait_irq("R11 completion");
        rd(3'd3, v); chk("R11 result", v, (3 << 6) | k_conv);
        k_conv++;

        repeat (20) @(negedge clk);
        chk("R2 all expected starts seen", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule